// File: doc/BRIEF.md
# Redundant Serial Command Decoder

This block takes serial command frames from two independent command lines, both sampled on the system clock, and turns them into one-cycle action strobes and a shared control register for a single addressed front-end readout chip. Two identical frame receivers, one per line, feed a common executor. The line idles low. A frame opens with a start bit of 1, then carries a 3-bit opcode and a 5-bit target address, both most significant bit first. When the opcode is a register load, 32 payload bits follow, also most significant bit first.

The two receivers are redundant paths to the same chip. A load of the control register is honoured from either path at any time. That lets a controller regain control through the spare line if the active one fails. Every other command is honoured only from the receiver that bit 0 of the control register currently selects. A frame is acted on when its address equals the chip's pin-strapped address or the broadcast address 0x1F. Any other frame is still shifted in to its end and then dropped.

Top module: `dual_cmd_decoder`

## Requirements
- R1: A frame whose start bit is sampled at clock edge k produces its strobe for exactly one cycle, starting at edge k+9. Opcode encoding: 010 read_evt_o, 011 cal_strobe_o, 100 evt_clear_o, 111 read_end_o. At most one of these strobes is high in any cycle.
- R2: Opcode 001 carries a 32-bit payload, most significant bit first. ctrl_o takes the payload at edge k+41 and keeps its old value until then.
- R3: A frame is acted on only if its address equals chip_addr_i or 0x1F. Any other frame produces no strobe and leaves ctrl_o unchanged.
- R4: Opcode 101 pulses chip_reset_o and fifo_reset_o together and clears ctrl_o to zero at the same edge.
- R5: Opcode 110 pulses fifo_reset_o alone and leaves ctrl_o unchanged.
- R6: Bit 0 of ctrl_o selects the command path: 0 selects line A and 1 selects line B. Commands other than 001 that arrive on the unselected line have no effect.
- R7: Opcode 001 is honoured from either line whatever the select bit.
- R8: When both lines complete a load in the same cycle, the payload from line A is taken.
- R9: rst_n low clears ctrl_o, drops all strobes and returns both receivers to idle. A partly received frame is discarded.
- R10: Opcode 000 causes no strobe and no register change.
- R11: A new start bit may follow the last bit of a frame with no idle cycle between them, and both frames are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the command lines are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_addr_i | input | 5 | Pin-strapped address of this chip |
| cmd_a_i | input | 1 | Serial command line A |
| cmd_b_i | input | 1 | Serial command line B |
| read_evt_o | output | 1 | Read-event strobe |
| cal_strobe_o | output | 1 | Calibration strobe |
| evt_clear_o | output | 1 | Strobe to drop the oldest buffered event |
| chip_reset_o | output | 1 | Chip-reset strobe |
| fifo_reset_o | output | 1 | Event-buffer reset strobe (chip reset or buffer reset) |
| read_end_o | output | 1 | End-of-readout strobe |
| ctrl_o | output | 32 | Control register contents |

## Verification
If the start bit is sampled at edge k, a strobe is due in the cycle after edge k+9, and a register load shows on ctrl_o in the cycle after edge k+41. After the last bit of each frame, the bench samples on three falling edges in turn. It expects nothing on the first, the predicted result on the second and nothing again on the third, so a result one cycle early or late is caught. The opcode sweep covers every opcode at all 32 addresses, and the expected strobes and register value are computed from the opcode and the address match. Back-to-back frames are checked by counting pulses.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_NOP     = 3'b000,
      OP_LOAD    = 3'b001,
      OP_READ    = 3'b010,
      OP_CAL     = 3'b011,
      OP_CLR     = 3'b100,
      OP_RSTCHIP = 3'b101,
      OP_RSTFIFO = 3'b110,
      OP_ENDRD   = 3'b111
   } opcode_e;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_OPC,
      RX_ADDR,
      RX_DATA
   } rx_state_e;
endpackage

// File: rtl/cmd_shift_rx.sv
module cmd_shift_rx
   import dcd_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output logic              done_o,
   output logic [OPC_W-1:0]  opc_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int MAXLEN = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
   localparam int CNT_W  = $clog2(MAXLEN + 1);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("cmd_shift_rx: ADDR_W must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("cmd_shift_rx: DATA_W must be at least 2");
   end

   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [OPC_W-1:0]  opc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         opc_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            RX_IDLE: begin
               cnt_q <= '0;
               if (line_i) state_q <= RX_OPC;
            end
            RX_OPC: begin
               opc_q <= {opc_q[OPC_W-2:0], line_i};
               if (cnt_q == CNT_W'(OPC_W - 1)) begin
                  cnt_q   <= '0;
                  state_q <= RX_ADDR;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_ADDR: begin
               if (ADDR_W > 1) addr_q <= {addr_q[ADDR_W-2:0], line_i};
               else            addr_q <= ADDR_W'(line_i);
               if (cnt_q == CNT_W'(ADDR_W - 1)) begin
                  cnt_q <= '0;
                  if (opc_q == OP_LOAD) begin
                     state_q <= RX_DATA;
                  end else begin
                     done_q  <= 1'b1;
                     state_q <= RX_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_DATA: begin
               data_q <= {data_q[DATA_W-2:0], line_i};
               if (cnt_q == CNT_W'(DATA_W - 1)) begin
                  cnt_q   <= '0;
                  done_q  <= 1'b1;
                  state_q <= RX_IDLE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign done_o = done_q;
   assign opc_o  = opc_q;
   assign addr_o = addr_q;
   assign data_o = data_q;

   // R1/R11: a frame completes in one pulse, and the receiver is idle right after it
   a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   a_r11_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> state_q == RX_IDLE);
endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
   import dcd_pkg::*;
#(
   parameter int          NDEC    = 2,
   parameter int          ADDR_W  = 5,
   parameter int          DATA_W  = 32,
   parameter int          SEL_BIT = 0,
   parameter logic [4:0]  BCAST   = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] chip_addr_i,
   input  logic              done_i [NDEC],
   input  logic [OPC_W-1:0]  opc_i  [NDEC],
   input  logic [ADDR_W-1:0] addr_i [NDEC],
   input  logic [DATA_W-1:0] data_i [NDEC],
   output logic              read_evt_o,
   output logic              cal_strobe_o,
   output logic              evt_clear_o,
   output logic              chip_reset_o,
   output logic              fifo_reset_o,
   output logic              read_end_o,
   output logic [DATA_W-1:0] ctrl_o
);
   localparam int SEL_W = (NDEC > 1) ? $clog2(NDEC) : 1;

   if (SEL_BIT + SEL_W > DATA_W) begin : g_bad_sel
      $error("cmd_exec: select field lies outside the control register");
   end
   if (NDEC < 1) begin : g_bad_ndec
      $error("cmd_exec: NDEC must be at least 1");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [SEL_W-1:0]  sel;
   logic [NDEC-1:0]   hit;
   logic              load_hit;
   logic [DATA_W-1:0] load_val;
   logic              cmd_v;
   logic [OPC_W-1:0]  cmd_op;
   logic              any_done;

   assign sel = ctrl_q[SEL_BIT +: SEL_W];

   for (genvar i = 0; i < NDEC; i++) begin : g_hit
      assign hit[i] = done_i[i] &&
                      ((addr_i[i] == chip_addr_i) || (addr_i[i] == ADDR_W'(BCAST)));
   end

   always_comb begin
      load_hit = 1'b0;
      load_val = '0;
      for (int i = NDEC - 1; i >= 0; i--) begin
         if (hit[i] && opc_i[i] == OP_LOAD) begin
            load_hit = 1'b1;
            load_val = data_i[i];
         end
      end
   end

   always_comb begin
      cmd_v  = 1'b0;
      cmd_op = OP_NOP;
      for (int i = 0; i < NDEC; i++) begin
         if (sel == SEL_W'(i) && hit[i] && opc_i[i] != OP_LOAD) begin
            cmd_v  = 1'b1;
            cmd_op = opc_i[i];
         end
      end
   end

   always_comb begin
      any_done = 1'b0;
      for (int i = 0; i < NDEC; i++) any_done = any_done | done_i[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q       <= '0;
         read_evt_o   <= 1'b0;
         cal_strobe_o <= 1'b0;
         evt_clear_o  <= 1'b0;
         chip_reset_o <= 1'b0;
         fifo_reset_o <= 1'b0;
         read_end_o   <= 1'b0;
      end else begin
         read_evt_o   <= cmd_v && cmd_op == OP_READ;
         cal_strobe_o <= cmd_v && cmd_op == OP_CAL;
         evt_clear_o  <= cmd_v && cmd_op == OP_CLR;
         chip_reset_o <= cmd_v && cmd_op == OP_RSTCHIP;
         fifo_reset_o <= cmd_v && (cmd_op == OP_RSTCHIP || cmd_op == OP_RSTFIFO);
         read_end_o   <= cmd_v && cmd_op == OP_ENDRD;
         if (cmd_v && cmd_op == OP_RSTCHIP) ctrl_q <= '0;
         else if (load_hit)                 ctrl_q <= load_val;
      end
   end

   assign ctrl_o = ctrl_q;

   // R1: never two action strobes at once
   a_r1_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({read_evt_o, cal_strobe_o, evt_clear_o, fifo_reset_o, read_end_o}));
   // R4: a chip reset also resets the buffer and leaves the register cleared
   a_r4_chip_with_fifo: assert property (@(posedge clk) disable iff (!rst_n)
      chip_reset_o |-> fifo_reset_o);
   a_r4_chip_clears_reg: assert property (@(posedge clk) disable iff (!rst_n)
      chip_reset_o |-> ctrl_q == '0);
   // R3/R6: a strobe or a register change needs a frame that completed one cycle before
   a_r6_strobe_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (read_evt_o || cal_strobe_o || evt_clear_o || fifo_reset_o || read_end_o)
      |-> $past(any_done));
   a_r2_reg_has_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_q) |-> $past(any_done));
endmodule

// File: rtl/dual_cmd_decoder.sv
module dual_cmd_decoder
   import dcd_pkg::*;
#(
   parameter int         ADDR_W  = 5,
   parameter int         DATA_W  = 32,
   parameter int         SEL_BIT = 0,
   parameter logic [4:0] BCAST   = 5'h1F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] chip_addr_i,
   input  logic              cmd_a_i,
   input  logic              cmd_b_i,
   output logic              read_evt_o,
   output logic              cal_strobe_o,
   output logic              evt_clear_o,
   output logic              chip_reset_o,
   output logic              fifo_reset_o,
   output logic              read_end_o,
   output logic [DATA_W-1:0] ctrl_o
);
   localparam int NDEC = 2;

   if (ADDR_W > 5) begin : g_bad_addr
      $error("dual_cmd_decoder: broadcast value is defined for at most 5 address bits");
   end

   logic [NDEC-1:0]   lines;
   logic              done   [NDEC];
   logic [OPC_W-1:0]  opc    [NDEC];
   logic [ADDR_W-1:0] addr   [NDEC];
   logic [DATA_W-1:0] data   [NDEC];

   assign lines = {cmd_b_i, cmd_a_i};

   for (genvar i = 0; i < NDEC; i++) begin : g_rx
      cmd_shift_rx #(
         .ADDR_W (ADDR_W),
         .DATA_W (DATA_W)
      ) u_rx (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (lines[i]),
         .done_o (done[i]),
         .opc_o  (opc[i]),
         .addr_o (addr[i]),
         .data_o (data[i])
      );
   end

   cmd_exec #(
      .NDEC    (NDEC),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .SEL_BIT (SEL_BIT),
      .BCAST   (BCAST)
   ) u_exec (
      .clk          (clk),
      .rst_n        (rst_n),
      .chip_addr_i  (chip_addr_i),
      .done_i       (done),
      .opc_i        (opc),
      .addr_i       (addr),
      .data_i       (data),
      .read_evt_o   (read_evt_o),
      .cal_strobe_o (cal_strobe_o),
      .evt_clear_o  (evt_clear_o),
      .chip_reset_o (chip_reset_o),
      .fifo_reset_o (fifo_reset_o),
      .read_end_o   (read_end_o),
      .ctrl_o       (ctrl_o)
   );
endmodule

// File: tb/dual_cmd_decoder_test.sv
module dual_cmd_decoder_test;
   localparam int         CLK_PERIOD = 10;
   localparam logic [4:0] OWN        = 5'h0B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_a = 1'b0;
   logic        cmd_b = 1'b0;
   logic        read_evt, cal_strobe, evt_clear, chip_reset, fifo_reset, read_end;
   logic [31:0] ctrl;

   int checks = 0;
   int errors = 0;
   int n_read = 0;
   int n_cal  = 0;
   logic [31:0] cur = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_cmd_decoder uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .chip_addr_i  (OWN),
      .cmd_a_i      (cmd_a),
      .cmd_b_i      (cmd_b),
      .read_evt_o   (read_evt),
      .cal_strobe_o (cal_strobe),
      .evt_clear_o  (evt_clear),
      .chip_reset_o (chip_reset),
      .fifo_reset_o (fifo_reset),
      .read_end_o   (read_end),
      .ctrl_o       (ctrl)
   );

   always @(negedge clk) begin
      if (read_evt)   n_read++;
      if (cal_strobe) n_cal++;
   end

   function automatic logic [5:0] strobes();
      return {read_evt, cal_strobe, evt_clear, chip_reset, fifo_reset, read_end};
   endfunction

   // {read, cal, clear, chip reset, fifo reset, end}
   function automatic logic [5:0] exp_vec(input logic [2:0] op, input logic hit);
      if (!hit) return 6'b0;
      case (op)
         3'b010:  return 6'b100000;
         3'b011:  return 6'b010000;
         3'b100:  return 6'b001000;
         3'b101:  return 6'b000110;
         3'b110:  return 6'b000010;
         3'b111:  return 6'b000001;
         default: return 6'b000000;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input bit b, input logic v);
      if (b) cmd_b = v;
      else   cmd_a = v;
   endtask

   task automatic send(input bit b, input logic [2:0] op, input logic [4:0] ad,
                       input logic [31:0] d);
      @(negedge clk) drive(b, 1'b1);
      for (int i = 2; i >= 0; i--) begin
         @(negedge clk) drive(b, op[i]);
      end
      for (int i = 4; i >= 0; i--) begin
         @(negedge clk) drive(b, ad[i]);
      end
      if (op == 3'b001) begin
         for (int i = 31; i >= 0; i--) begin
            @(negedge clk) drive(b, d[i]);
         end
      end
   endtask

   // lines go idle; nothing yet, then the result for one cycle, then nothing
   task automatic check_after(input string req, input logic [5:0] ev,
                              input logic [31:0] old_c, input logic [31:0] new_c);
      @(negedge clk) begin cmd_a = 1'b0; cmd_b = 1'b0; end
      chk(req, {26'b0, strobes()}, 32'b0);
      chk(req, ctrl, old_c);
      @(negedge clk);
      chk(req, {26'b0, strobes()}, {26'b0, ev});
      chk(req, ctrl, new_c);
      @(negedge clk);
      chk(req, {26'b0, strobes()}, 32'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 reset", {26'b0, strobes()}, 32'b0);
      chk("R9 reset", ctrl, 32'b0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);

      // R1 R2 R3 R4 R5 R10: every opcode at every address on line A (selected)
      for (int op = 0; op < 8; op++) begin
         for (int ad = 0; ad < 32; ad++) begin
            logic        hit;
            logic [31:0] d;
            logic [31:0] nxt;
            hit = (5'(ad) == OWN) || (ad == 31);
            d   = 32'h9E37_79B8 ^ (32'(ad) << 8);
            nxt = cur;
            if (hit && op == 1) nxt = d;
            if (hit && op == 5) nxt = '0;
            send(1'b0, 3'(op), 5'(ad), d);
            check_after("R1 R2 R3 R4 R5 R10 sweep", exp_vec(3'(op), hit), cur, nxt);
            cur = nxt;
         end
      end

      // R5: buffer reset leaves a loaded register unchanged
      send(1'b0, 3'b001, OWN, 32'h1234_5678);
      check_after("R2 load", 6'b0, cur, 32'h1234_5678);
      cur = 32'h1234_5678;
      send(1'b0, 3'b110, OWN, 0);
      check_after("R5 fifo reset keeps reg", 6'b000010, cur, cur);
      // R4: chip reset clears it
      send(1'b0, 3'b101, 5'h1F, 0);
      check_after("R4 chip reset clears", 6'b000110, cur, 32'h0);
      cur = 0;

      // R7: line B loads while line A is selected
      send(1'b1, 3'b001, OWN, 32'hCAFE_0010);
      check_after("R7 load from unselected", 6'b0, cur, 32'hCAFE_0010);
      cur = 32'hCAFE_0010;
      // R6: line B commands ignored while A selected
      send(1'b1, 3'b010, OWN, 0);
      check_after("R6 B ignored", 6'b0, cur, cur);
      // R6: select line B (bit 0 = 1), loaded through line A
      send(1'b0, 3'b001, OWN, 32'h0000_0001);
      check_after("R6 select B", 6'b0, cur, 32'h1);
      cur = 32'h1;
      send(1'b0, 3'b010, OWN, 0);
      check_after("R6 A ignored", 6'b0, cur, cur);
      send(1'b1, 3'b011, OWN, 0);
      check_after("R6 B obeyed", 6'b010000, cur, cur);
      send(1'b1, 3'b001, 5'h1F, 32'h0000_0100);
      check_after("R7 B returns select", 6'b0, cur, 32'h100);
      cur = 32'h100;
      send(1'b0, 3'b111, OWN, 0);
      check_after("R6 A obeyed again", 6'b000001, cur, cur);

      // R8: simultaneous loads, A wins
      fork
         send(1'b0, 3'b001, OWN, 32'hAAAA_5550);
         send(1'b1, 3'b001, OWN, 32'h5555_AAA0);
      join
      check_after("R8 A priority", 6'b0, cur, 32'hAAAA_5550);
      cur = 32'hAAAA_5550;

      // R11: back-to-back frames on line A
      begin
         int r0, c0;
         r0 = n_read;
         c0 = n_cal;
         send(1'b0, 3'b010, OWN, 0);
         send(1'b0, 3'b011, OWN, 0);
         @(negedge clk) cmd_a = 1'b0;
         repeat (4) @(negedge clk);
         chk("R11 back-to-back read", 32'(n_read - r0), 32'd1);
         chk("R11 back-to-back cal", 32'(n_cal - c0), 32'd1);
      end

      // R9: reset in mid-frame discards the frame and clears the register
      @(negedge clk) cmd_a = 1'b1;
      @(negedge clk) cmd_a = 1'b0;
      @(negedge clk) cmd_a = 1'b1;
      @(negedge clk) begin cmd_a = 1'b0; rst_n = 1'b0; end
      @(negedge clk);
      chk("R9 reg cleared", ctrl, 32'h0);
      @(negedge clk) rst_n = 1'b1;
      repeat (12) @(negedge clk) chk("R9 aborted frame silent", {26'b0, strobes()}, 32'b0);
      cur = 0;
      send(1'b0, 3'b100, OWN, 0);
      check_after("R9 decodes after reset", 6'b001000, cur, cur);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule